// File: doc/BRIEF.md
# SPI Slave with Prefetching Transmit Queue

This block is an SPI slave for mode 0: the clock idles low, the master samples on the rising edge, frames are 8 bits and the most significant bit goes first. The serial pins and the active-low select are treated as slow asynchronous levels. Each one passes through a two-flop synchronizer, and the block detects the clock edges inside the system clock domain. Select is a plain level. No pulse is inserted between frames.

Each direction has its own queue of 32 bits of storage, which is four byte slots. The transmit queue refills itself through a request/data port on the memory side. It asks for data whenever it holds two bytes or fewer, and it never holds more than three. Bytes are therefore fetched long before the master starts clocking. A change to the source memory shows up on the wire only after the bytes already queued have been sent. Received frames collect in a four-entry queue with a valid/ready output.

Two sticky flags report errors. Underrun is set when the master starts a frame while the transmit queue is empty; that frame goes out as zeros. Overrun is set when a frame completes while the receive queue is full; that frame is dropped. A single-cycle clear input clears both flags.

Top module: `spi_prefetch_slave`

## Requirements
- R1: Received bits are taken at each synchronized rising SCK edge, most significant bit first. After eight rising edges with select active, the assembled byte is queued for the receive side.
- R2: Before the first rising edge of a frame, MISO shows bit 7 of the transmit queue head. Within a frame, MISO moves to the next lower bit only at a falling SCK edge and holds its value across a rising edge.
- R3: The transmit queue stores at most three bytes. A write offered while it holds three is ignored and is never transmitted.
- R4: fill_req is high while the transmit queue holds two bytes or fewer and low when it holds three.
- R5: A transmit byte is taken from the queue at the first rising edge of its frame. When the source memory changes while three bytes are queued, the next frames still carry the three older bytes before any newer byte.
- R6: The receive queue holds up to four frames and returns them in arrival order. While rx_valid is high and rx_ready is low, rx_valid and rx_data stay unchanged.
- R7: A frame that completes while the receive queue holds four frames is dropped and sets the sticky overrun flag. The flag is not set before that frame completes.
- R8: A frame whose first rising edge finds the transmit queue empty is sent as 0x00 and sets the sticky underrun flag.
- R9: If select goes inactive partway through a frame, the partial frame is discarded and the bit counter restarts. The next full frame is received intact.
- R10: A one-cycle pulse on flag_clr clears both flags. If a set condition occurs in the same cycle, the set takes priority.
- R11: MISO is driven low while select is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sck | input | 1 | Serial clock from master, asynchronous |
| spi_mosi | input | 1 | Serial data from master, asynchronous |
| spi_cs_n | input | 1 | Active-low select, asynchronous |
| spi_miso | output | 1 | Serial data to master |
| fill_req | output | 1 | Transmit queue asks for more bytes |
| fill_valid | input | 1 | Byte offered to the transmit queue |
| fill_data | input | 8 | Offered transmit byte |
| rx_data | output | 8 | Oldest received frame |
| rx_valid | output | 1 | Receive queue not empty |
| rx_ready | input | 1 | Consumer takes rx_data this cycle |
| flag_clr | input | 1 | Clear both sticky flags |
| underrun | output | 1 | Sticky: frame started with empty transmit queue |
| overrun | output | 1 | Sticky: frame dropped on full receive queue |

## Verification
A change on SCK, MOSI or select reaches the shifter's state on the third clock edge after it: two synchronizer stages, then the edge-detect register. MISO and the receive queue reflect that change from the same edge, and a queue write offered at one edge changes fill_req by the next. The bench therefore holds every serial level for six clocks. It samples MISO, the flags and the receive outputs only on the sixth falling clock edge after the last serial change, and it raises fill_valid one clock after it sees fill_req, so that every write it offers is accepted.

// File: rtl/spi_pf_pkg.sv
package spi_pf_pkg;

    // Sticky error flags kept by the top level.
    typedef struct packed {
        logic underrun;
        logic overrun;
    } pf_flags_t;

    // Next value of one sticky flag; a new event beats a clear.
    function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/spi_pf_sync.sv
module spi_pf_sync #(
    parameter int          N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.s1 = async_in;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            q <= d;
        end
    end

    assign sync_out = q.s2;
endmodule

// File: rtl/spi_pf_fifo.sv
// Ring buffer of DEPTH slots (power of two) that admits at most CAP entries.
module spi_pf_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int CAP   = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [LW-1:0]           lvl;
    } fifo_t;

    fifo_t q, d;
    logic  push_ok, pop_ok;

    assign full    = (q.lvl == LW'(CAP));
    assign empty   = (q.lvl == '0);
    assign push_ok = push & ~full;
    assign pop_ok  = pop & ~empty;

    always_comb begin
        d = q;
        if (push_ok) begin
            d.mem[q.wp] = wdata;
            d.wp        = q.wp + 1'b1;
        end
        if (pop_ok) begin
            d.rp = q.rp + 1'b1;
        end
        d.lvl = q.lvl + LW'(push_ok) - LW'(pop_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata = q.mem[q.rp];
    assign level = q.lvl;

    // R3 / R7: a write offered to a full queue leaves the fill level as it was.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (level == $past(level)));

    // R6: a read from a non-empty queue with no write lowers the level by one.
    a_r6_pop_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push) |=> (level == $past(level) - 1'b1));
endmodule

// File: rtl/spi_pf_shifter.sv
// Frame engine in the system clock domain, fed by synchronized serial levels.
module spi_pf_shifter #(
    parameter int W   = 8,
    localparam int CW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sck_s,
    input  logic         mosi_s,
    input  logic         cs_act,
    input  logic [W-1:0] tx_head,
    input  logic         tx_empty,
    input  logic         rx_full,
    output logic         tx_pop,
    output logic         rx_push,
    output logic [W-1:0] rx_word,
    output logic         miso,
    output logic         underrun_set,
    output logic         overrun_set
);
    typedef struct packed {
        logic          sck_p;
        logic [CW-1:0] cnt;
        logic [W-1:0]  tx;
        logic [W-1:0]  rx;
    } sh_t;

    sh_t  q, d;
    logic rise, fall, frame_end;

    assign rise      = sck_s & ~q.sck_p;
    assign fall      = ~sck_s & q.sck_p;
    assign frame_end = (q.cnt == CW'(W - 1));
    assign rx_word   = {q.rx[W-2:0], mosi_s};

    always_comb begin
        d            = q;
        d.sck_p      = sck_s;
        tx_pop       = 1'b0;
        rx_push      = 1'b0;
        underrun_set = 1'b0;
        overrun_set  = 1'b0;
        if (!cs_act) begin
            d.cnt = '0;
        end else if (rise) begin
            if (q.cnt == '0) begin
                tx_pop       = ~tx_empty;
                underrun_set = tx_empty;
                d.tx         = tx_empty ? '0 : tx_head;
            end
            d.rx = rx_word;
            if (frame_end) begin
                d.cnt       = '0;
                rx_push     = ~rx_full;
                overrun_set = rx_full;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else if (fall && (q.cnt != '0)) begin
            d.tx = {q.tx[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        if (!cs_act) begin
            miso = 1'b0;
        end else if (q.cnt == '0) begin
            miso = ~tx_empty & tx_head[W-1];
        end else begin
            miso = q.tx[W-1];
        end
    end

    // R9: with select inactive, the bit counter is back at zero on the next cycle.
    a_r9_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (q.cnt == '0));

    // R2: inside a frame the outgoing shift register does not move on a rising edge.
    a_r2_hold_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && rise && (q.cnt != '0)) |=> (q.tx == $past(q.tx)));

    // R8: a frame that starts on an empty queue sends an all-zero byte.
    a_r8_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && rise && (q.cnt == '0) && tx_empty) |=> (q.tx == '0));
endmodule

// File: rtl/spi_prefetch_slave.sv
module spi_prefetch_slave #(
    parameter int FRAME_W   = 8,
    parameter int FIFO_BITS = 32,
    localparam int DEPTH    = FIFO_BITS / FRAME_W,
    localparam int TX_CAP   = DEPTH - 1,
    localparam int LW       = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sck,
    input  logic               spi_mosi,
    input  logic               spi_cs_n,
    output logic               spi_miso,
    output logic               fill_req,
    input  logic               fill_valid,
    input  logic [FRAME_W-1:0] fill_data,
    output logic [FRAME_W-1:0] rx_data,
    output logic               rx_valid,
    input  logic               rx_ready,
    input  logic               flag_clr,
    output logic               underrun,
    output logic               overrun
);
    import spi_pf_pkg::*;

    logic [2:0]         pins_s;
    logic               sck_s, mosi_s, cs_act;
    logic [FRAME_W-1:0] tx_head, rx_word;
    logic [LW-1:0]      tx_lvl, rx_lvl;
    logic               tx_full, tx_empty, tx_pop;
    logic               rx_full, rx_empty, rx_push;
    logic               under_set, over_set;
    pf_flags_t          flg_q, flg_d;

    spi_pf_sync #(.N(3), .RST_VAL(3'b100)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({spi_cs_n, spi_mosi, spi_sck}),
        .sync_out (pins_s)
    );

    assign sck_s  = pins_s[0];
    assign mosi_s = pins_s[1];
    assign cs_act = ~pins_s[2];

    spi_pf_fifo #(.W(FRAME_W), .DEPTH(DEPTH), .CAP(TX_CAP)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fill_valid),
        .wdata (fill_data),
        .pop   (tx_pop),
        .rdata (tx_head),
        .level (tx_lvl),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spi_pf_fifo #(.W(FRAME_W), .DEPTH(DEPTH), .CAP(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (rx_word),
        .pop   (rx_valid & rx_ready),
        .rdata (rx_data),
        .level (rx_lvl),
        .full  (rx_full),
        .empty (rx_empty)
    );

    spi_pf_shifter #(.W(FRAME_W)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .sck_s        (sck_s),
        .mosi_s       (mosi_s),
        .cs_act       (cs_act),
        .tx_head      (tx_head),
        .tx_empty     (tx_empty),
        .rx_full      (rx_full),
        .tx_pop       (tx_pop),
        .rx_push      (rx_push),
        .rx_word      (rx_word),
        .miso         (spi_miso),
        .underrun_set (under_set),
        .overrun_set  (over_set)
    );

    assign fill_req = (tx_lvl <= LW'(DEPTH / 2));
    assign rx_valid = ~rx_empty;

    always_comb begin
        flg_d          = flg_q;
        flg_d.underrun = sticky_next(flg_q.underrun, under_set, flag_clr);
        flg_d.overrun  = sticky_next(flg_q.overrun, over_set, flag_clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign underrun = flg_q.underrun;
    assign overrun  = flg_q.overrun;

    // R3: the transmit queue never holds more than its three-entry cap.
    a_r3_tx_cap: assert property (@(posedge clk) disable iff (!rst_n)
        tx_lvl <= LW'(TX_CAP));

    // R4: with the request low the queue sits at its cap, so a write changes nothing.
    a_r4_idle_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_req && !tx_pop) |=> (tx_lvl == $past(tx_lvl)));

    // R6: a held receive output does not change.
    a_r6_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    // R6: the receive queue never exceeds four frames.
    a_r6_rx_cap: assert property (@(posedge clk) disable iff (!rst_n)
        rx_lvl <= LW'(DEPTH));

    // R10: flags stay set until cleared.
    a_r10_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !flag_clr) |=> underrun);
    a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !flag_clr) |=> overrun);

    // R10: a clear with no new event leaves both flags low.
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !under_set && !over_set) |=> (!underrun && !overrun));
endmodule

// File: tb/spi_prefetch_slave_test.sv
module spi_prefetch_slave_test;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b1;
    logic       spi_miso, fill_req;
    logic       fill_valid;
    logic [7:0] fill_data;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready = 1'b0, flag_clr = 1'b0;
    logic       underrun, overrun;

    // Fill sources: a one-shot forced burst and an automatic responder.
    logic       man_v = 1'b0;
    logic [7:0] man_d = '0;
    logic       auto_v;
    logic [7:0] auto_d;
    int         fill_mode = 0;          // 0 off, 1 four-byte ring, 2 counter
    logic [7:0] ring [4];
    int         ptr;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign fill_valid = man_v | auto_v;
    assign fill_data  = man_v ? man_d : auto_d;

    always @(negedge clk) begin
        if (!rst_n) begin
            auto_v <= 1'b0;
            auto_d <= '0;
            ptr    <= 0;
        end else if (fill_mode != 0 && fill_req && !man_v) begin
            auto_v <= 1'b1;
            auto_d <= (fill_mode == 1) ? ring[ptr % 4] : (8'(ptr) ^ 8'h5A);
            ptr    <= ptr + 1;
        end else begin
            auto_v <= 1'b0;
        end
    end

    spi_prefetch_slave uut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .fill_req(fill_req),
        .fill_valid(fill_valid), .fill_data(fill_data), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .flag_clr(flag_clr),
        .underrun(underrun), .overrun(overrun)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input int mode);
        fill_mode = 0;
        rst_n = 1'b0;
        spi_cs_n = 1'b1;
        spi_sck = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        fill_mode = mode;
        wait_clk(HALF);
    endtask

    task automatic sel(input logic on);
        spi_cs_n = ~on;
        wait_clk(HALF);
    endtask

    // One frame; optionally checks each MISO bit and the received byte.
    task automatic frame(input logic [7:0] mo, input logic [7:0] mi,
                         input bit chk_mi, input bit chk_rx, input bit pop_rx);
        for (int b = 7; b >= 0; b--) begin
            spi_mosi = mo[b];
            wait_clk(HALF);
            if (chk_mi) chk("R2 bit before rise", {7'b0, spi_miso}, {7'b0, mi[b]});
            spi_sck = 1'b1;
            wait_clk(HALF);
            if (chk_mi && b != 0) chk("R2 hold across rise", {7'b0, spi_miso}, {7'b0, mi[b]});
            spi_sck = 1'b0;
        end
        wait_clk(HALF);
        if (chk_rx) begin
            chk("R1 rx_valid", {7'b0, rx_valid}, 8'h01);
            chk("R1 rx_data", rx_data, mo);
        end
        if (pop_rx) begin
            rx_ready = 1'b1;
            wait_clk(1);
            rx_ready = 1'b0;
        end
    endtask

    task automatic pulse_clr;
        flag_clr = 1'b1;
        wait_clk(1);
        flag_clr = 1'b0;
        wait_clk(2);
    endtask

    initial begin
        // Scenario A: reset state, forced fill beyond the cap, underrun.
        do_reset(0);
        chk("R11 miso idle", {7'b0, spi_miso}, 8'h00);
        chk("R6 rx_valid at reset", {7'b0, rx_valid}, 8'h00);
        chk("R10 flags at reset", {6'b0, underrun, overrun}, 8'h00);
        chk("R4 fill_req empty", {7'b0, fill_req}, 8'h01);
        for (int i = 0; i < 4; i++) begin
            man_v = 1'b1;
            man_d = 8'hA1 + 8'(i);
            wait_clk(1);
            if (i == 1) chk("R4 fill_req at two", {7'b0, fill_req}, 8'h01);
        end
        man_v = 1'b0;
        wait_clk(1);
        chk("R4 fill_req at three", {7'b0, fill_req}, 8'h00);
        sel(1'b1);
        frame(8'h3C, 8'hA1, 1, 1, 1);
        chk("R4 fill_req after one taken", {7'b0, fill_req}, 8'h01);
        frame(8'hC3, 8'hA2, 1, 1, 1);
        frame(8'h00, 8'hA3, 1, 1, 1);
        chk("R8 no early underrun", {7'b0, underrun}, 8'h00);
        frame(8'hFF, 8'h00, 1, 1, 1);   // R3: A4 was refused, R8: zeros
        chk("R8 underrun set", {7'b0, underrun}, 8'h01);
        sel(1'b0);
        chk("R11 miso after deselect", {7'b0, spi_miso}, 8'h00);
        pulse_clr;
        chk("R10 cleared", {6'b0, underrun, overrun}, 8'h00);

        // Scenario B: stale prefetched bytes precede the new memory contents.
        for (int i = 0; i < 4; i++) ring[i] = 8'h58;
        do_reset(1);
        wait_clk(10);
        for (int i = 0; i < 4; i++) ring[i] = 8'h21;
        sel(1'b1);
        frame(8'h01, 8'h58, 1, 1, 1);
        frame(8'h02, 8'h58, 1, 1, 1);
        frame(8'h03, 8'h58, 1, 1, 1);
        frame(8'h04, 8'h21, 1, 1, 1);   // R5
        sel(1'b0);
        sel(1'b1);
        for (int i = 0; i < 4; i++) frame(8'h10 + 8'(i), 8'h21, 1, 1, 1);   // R5
        sel(1'b0);
        chk("R8 no underrun with refill", {7'b0, underrun}, 8'h00);

        // Scenario C: sweep all MOSI codes; counter source gives frame k = k ^ 5A.
        do_reset(2);
        sel(1'b1);
        for (int k = 0; k < 256; k++) frame(8'(k), 8'(k) ^ 8'h5A, 1, 1, 1);
        sel(1'b0);

        // Scenario D: partial frame (R9); it still consumed transmit byte 256.
        sel(1'b1);
        for (int b = 0; b < 3; b++) begin
            spi_mosi = 1'b1;
            wait_clk(HALF);
            spi_sck = 1'b1;
            wait_clk(HALF);
            spi_sck = 1'b0;
        end
        sel(1'b0);
        chk("R9 partial frame dropped", {7'b0, rx_valid}, 8'h00);
        sel(1'b1);
        frame(8'h96, 8'h01 ^ 8'h5A, 1, 1, 1);   // R9
        sel(1'b0);

        // Scenario E: receive queue of four, overrun on the fifth (R6, R7).
        do_reset(2);
        sel(1'b1);
        for (int i = 1; i <= 4; i++) frame(8'h11 * 8'(i), 8'h00, 0, 0, 0);
        chk("R7 no early overrun", {7'b0, overrun}, 8'h00);
        frame(8'h55, 8'h00, 0, 0, 0);
        sel(1'b0);
        chk("R7 overrun set", {7'b0, overrun}, 8'h01);
        wait_clk(10);
        chk("R6 held head", rx_data, 8'h11);
        for (int i = 1; i <= 4; i++) begin
            chk("R6 valid", {7'b0, rx_valid}, 8'h01);
            chk("R6 order", rx_data, 8'h11 * 8'(i));
            rx_ready = 1'b1;
            wait_clk(1);
            rx_ready = 1'b0;
        end
        chk("R7 fifth frame dropped", {7'b0, rx_valid}, 8'h00);
        pulse_clr;
        chk("R10 overrun cleared", {7'b0, overrun}, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule